// File: doc/BRIEF.md
# Cube Computation Unit (Duplex Square, Crosswise Product)

This block raises an unsigned operand of `WIDTH` bits to the third power and returns the exact result on `3*WIDTH` bits, so it never truncates or saturates. The cube is formed in two stages. The first stage squares the operand with a duplex squarer. Each square column adds twice every mirrored pair of operand bits whose indices sum to the column number, plus the lone middle bit when the column is even.

The second stage multiplies the `2*WIDTH`-bit square by the original operand using vertical-and-crosswise columns. Column k adds every product of square bit i and operand bit j with i+j=k. In both stages each column keeps a single bit and passes the rest of its sum upward as a carry. The highest position receives only the final carry.

The block is meant as a datapath cell in signal-processing pipelines. A parameter decides whether the result leaves through combinational logic or through an output register that adds one clock of latency.

Top module: `cube_engine`

## Requirements
- R1: For every operand value, the combinational variant (`REG_OUT`=0) drives `cube_o` equal to operand³ on all `3*WIDTH` bits in the same cycle.
- R2: In the registered variant (`REG_OUT`=1), the cube of the operand present at a rising clock edge appears on `cube_o` after that edge and holds until the next edge.
- R3: The internal square equals operand² on `2*WIDTH` bits, so for any nonzero operand `cube_o` divided by the operand is exactly operand².
- R4: Bit 0 of the square equals operand bit 0, and bit 1 of the square is always 0.
- R5: Bit 0 of `cube_o` equals bit 0 of the operand that produced it.
- R6: `rst_n` is asynchronous and active low. While it is low, the registered variant drives `cube_o` to 0 whatever the operand.
- R7: Boundary values: operand 0 gives 0, operand 9 gives 729 (binary 1011011001), and the all-ones operand gives (2^WIDTH-1)³, which is 16581375 at 8 bits.
- R8: An even operand gives a cube whose three least significant bits are 0.
- R9: An operand of 2^m gives a cube with exactly one bit set, at position 3m.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| operand_i | input | WIDTH | Unsigned value to be cubed |
| cube_o | output | 3*WIDTH | Unsigned cube of the operand |

## Verification
A wrong column sum or a lost carry in either stage shows up on `cube_o` for every operand that activates that column. With the combinational variant it is visible in the same cycle. With the registered variant it is visible after the next rising edge. Sweeping all operand values exercises each column across its full range of sums, so a fault cannot hide. The boundary operands and powers of two pin down the top carry and the exact position of each column.

// File: rtl/cube_pkg.sv
package cube_pkg;
   // Bits needed to hold a column sum plus the incoming carry for a column
   // that can gather up to `terms` single-bit products (with headroom).
   function automatic int col_sum_bits(input int terms);
      return $clog2(4 * terms + 4) + 1;
   endfunction

   function automatic int cube_bits(input int w);
      return 3 * w;
   endfunction
endpackage

// File: rtl/carry_ripple.sv
module carry_ripple #(
   parameter int NCOL = 15,
   parameter int SW   = 6
) (
   input  logic [NCOL*SW-1:0] cols_i,
   output logic [NCOL:0]      sum_o
);
   // Each column keeps its low bit; the remainder moves to the next column.
   always_comb begin
      logic [SW-1:0] acc;
      acc = '0;
      for (int k = 0; k < NCOL; k++) begin
         acc      = acc + cols_i[k*SW +: SW];
         sum_o[k] = acc[0];
         acc      = acc >> 1;
      end
      sum_o[NCOL] = acc[0];
   end
endmodule

// File: rtl/duplex_squarer.sv
module duplex_squarer #(
   parameter int W = 8
) (
   input  logic [W-1:0]   a_i,
   output logic [2*W-1:0] sq_o
);
   localparam int NCOL = 2 * W - 1;
   localparam int SW   = cube_pkg::col_sum_bits(W);

   logic [NCOL*SW-1:0] cols;

   for (genvar c = 0; c < NCOL; c++) begin : g_col
      logic [W-1:0] pair;
      logic         mid;
      for (genvar i = 0; i < W; i++) begin : g_pair
         if ((i < c - i) && (c - i < W)) begin : g_on
            assign pair[i] = a_i[i] & a_i[c-i];
         end else begin : g_off
            assign pair[i] = 1'b0;
         end
      end
      if (c % 2 == 0) begin : g_mid
         assign mid = a_i[c/2];
      end else begin : g_nomid
         assign mid = 1'b0;
      end
      assign cols[c*SW +: SW] = SW'(2 * $countones(pair)) + SW'(mid);
   end

   carry_ripple #(.NCOL(NCOL), .SW(SW)) u_ripple (
      .cols_i (cols),
      .sum_o  (sq_o)
   );
endmodule

// File: rtl/crosswise_multiplier.sv
module crosswise_multiplier #(
   parameter int AW = 16,
   parameter int BW = 8
) (
   input  logic [AW-1:0]    a_i,
   input  logic [BW-1:0]    b_i,
   output logic [AW+BW-1:0] p_o
);
   localparam int NCOL = AW + BW - 1;
   localparam int SW   = cube_pkg::col_sum_bits(AW + BW);

   logic [NCOL*SW-1:0] cols;

   for (genvar k = 0; k < NCOL; k++) begin : g_col
      logic [AW-1:0] term;
      for (genvar i = 0; i < AW; i++) begin : g_term
         if ((k - i >= 0) && (k - i < BW)) begin : g_on
            assign term[i] = a_i[i] & b_i[k-i];
         end else begin : g_off
            assign term[i] = 1'b0;
         end
      end
      assign cols[k*SW +: SW] = SW'($countones(term));
   end

   carry_ripple #(.NCOL(NCOL), .SW(SW)) u_ripple (
      .cols_i (cols),
      .sum_o  (p_o)
   );
endmodule

// File: rtl/cube_engine.sv
module cube_engine #(
   parameter int WIDTH   = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [WIDTH-1:0]                    operand_i,
   output logic [cube_pkg::cube_bits(WIDTH)-1:0] cube_o
);
   localparam int SQW = 2 * WIDTH;
   localparam int CW  = cube_pkg::cube_bits(WIDTH);

   if (WIDTH < 2) begin : g_bad_narrow
      $error("cube_engine: WIDTH must be at least 2");
   end
   if (WIDTH > 32) begin : g_bad_wide
      $error("cube_engine: WIDTH above 32 is not supported");
   end

   logic [SQW-1:0] square_w;
   logic [CW-1:0]  prod_w;

   duplex_squarer #(.W(WIDTH)) u_square (
      .a_i  (operand_i),
      .sq_o (square_w)
   );

   crosswise_multiplier #(.AW(SQW), .BW(WIDTH)) u_mult (
      .a_i (square_w),
      .b_i (operand_i),
      .p_o (prod_w)
   );

   if (REG_OUT) begin : g_reg
      logic [CW-1:0] cube_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cube_q <= '0;
         else        cube_q <= prod_w;
      end
      assign cube_o = cube_q;
   end else begin : g_comb
      assign cube_o = prod_w;
   end
endmodule

// File: rtl/cube_engine_chk.sv
module cube_engine_chk #(
   parameter int WIDTH   = 8,
   parameter bit REG_OUT = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [WIDTH-1:0]     op_i,
   input logic [2*WIDTH-1:0]   sq_i,
   input logic [3*WIDTH-1:0]   cube_i
);
   localparam int SQW = 2 * WIDTH;
   localparam int CW  = 3 * WIDTH;

   logic [SQW-1:0] sq_ref;
   logic [CW-1:0]  cube_ref;
   assign sq_ref   = SQW'(op_i) * SQW'(op_i);
   assign cube_ref = CW'(op_i) * CW'(op_i) * CW'(op_i);

   assert_square_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sq_i == sq_ref);

   assert_sq_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_i[0] == op_i[0]) && (sq_i[1] == 1'b0));

   if (REG_OUT) begin : g_reg
      assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> cube_i == $past(cube_ref));
      assert_lsb_R5: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> cube_i[0] == $past(op_i[0]));
      assert_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && !$past(op_i[0])) |-> cube_i[2:0] == 3'b000);
      assert_reset_R6: assert property (@(posedge clk)
         !rst_n |-> cube_i == '0);
   end else begin : g_comb
      assert_cube_R1: assert property (@(posedge clk) disable iff (!rst_n)
         cube_i == cube_ref);
      assert_lsb_R5: assert property (@(posedge clk) disable iff (!rst_n)
         cube_i[0] == op_i[0]);
      assert_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !op_i[0] |-> cube_i[2:0] == 3'b000);
   end
endmodule

bind cube_engine cube_engine_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .op_i   (operand_i),
   .sq_i   (square_w),
   .cube_i (cube_o)
);

// File: tb/cube_engine_tb.sv
`timescale 1ns/1ps
module cube_engine_tb;
   localparam int W  = 8;
   localparam int CW = 3 * W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b1;
   logic [W-1:0]  op = '0;
   logic [CW-1:0] cube_reg, cube_comb;

   int checks = 0;
   int bad    = 0;
   longint q[$];

   always #4 clk = ~clk;

   cube_engine #(.WIDTH(W), .REG_OUT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .operand_i(op), .cube_o(cube_reg));
   cube_engine #(.WIDTH(W), .REG_OUT(1'b0)) u_dut_comb (
      .clk(clk), .rst_n(rst_n), .operand_i(op), .cube_o(cube_comb));

   function automatic longint cube_of(input longint v);
      return v * v * v;
   endfunction

   task automatic check(input string tag, input longint got, input longint exp);
      checks++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s op=%0d got=%0d exp=%0d", tag, op, got, exp);
      end
   endtask

   // Compare registered output with model, then apply a new operand.
   task automatic step(input int v);
      @(negedge clk);
      if (q.size() > 0) check("R2 registered cube", longint'(cube_reg), q.pop_front());
      op = W'(v);
      q.push_back(cube_of(v));
      #1;
      check("R1 comb cube", longint'(cube_comb), cube_of(v));
      check("R5 lsb", longint'(cube_comb[0]), longint'(v % 2));
      if (v % 2 == 0) check("R8 even low bits", longint'(cube_comb[2:0]), 0);
      if (v != 0) begin
         longint s;
         s = longint'(cube_comb) / v;
         check("R3 square via quotient", s, longint'(v) * v);
         check("R4 square bit1", (s >> 1) & 1, 0);
      end
   endtask

   initial begin
      #1 rst_n = 1'b0;
      op = 8'd77;
      @(negedge clk);
      check("R6 reset output", longint'(cube_reg), 0);
      @(negedge clk);
      rst_n = 1'b1;
      // R1/R2/R3/R5/R8: exhaustive sweep
      for (int v = 0; v < (1 << W); v++) step(v);
      // R7: boundary points, in two orders
      step(0);   check("R7 zero", longint'(cube_comb), 0);
      step(9);   check("R7 nine", longint'(cube_comb), 729);
      step(255); check("R7 max", longint'(cube_comb), 16581375);
      step(0);   check("R7 zero after max", longint'(cube_comb), 0);
      step(255); step(9);
      // R9: powers of two give a single bit at 3m
      for (int m = 0; m < W; m++) begin
         step(1 << m);
         check("R9 single bit", longint'(cube_comb), longint'(1) << (3 * m));
      end
      // R2: operand held steady keeps output steady
      step(200); step(200); step(200);
      @(negedge clk);
      check("R2 hold", longint'(cube_reg), cube_of(200));
      q.delete();
      // R6: asynchronous reset with a nonzero operand
      op = 8'd123;
      #1 rst_n = 1'b0;
      #1 check("R6 async clear", longint'(cube_reg), 0);
      @(negedge clk);
      check("R6 held in reset", longint'(cube_reg), 0);
      rst_n = 1'b1;
      step(123);
      step(5);
      step(5);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule